// File: doc/BRIEF.md
# Indirect Byte-Register Access Port

This block gives a host a narrow window onto a bank of small configuration registers. The host sees a single 32-bit port register, which it writes and reads over a simple strobe interface. Packed into that word are a port-level reset, a read/write direction bit, a bank address, a byte of write data and a byte of read data. The bank behind the port has 32 entries of 8 bits each, and some of those entries are populated. Typical contents are enables and gain settings for analog circuitry.

A write follows four steps. The host takes the port out of reset, sets the address, sets the data, and then raises the direction bit. The entry is updated only on the 0-to-1 step of that bit. A read has three steps. The host clears the direction bit, sets the address, and then reads the port word, whose low byte shows the addressed entry. A handful of bank fields drive output ports so that the rest of the chip can observe them.

Top module: `indirect_reg_port`

## Requirements
- R1: After `rst_n` is released, `host_rdata` reads 0x00000000 and every observation output is 0. The port-reset bit therefore starts at 0, which means the port is held.
- R2: While port-reset bit 28 reads 0 (active low), every bank entry is held at 0x00 and commit attempts are ignored. Clearing the bit also wipes entries that were written earlier.
- R3: A host write that moves mode bit 24 from 0 to 1, with bit 28 equal to 1 in the same word, stores bits 15:8 into the entry addressed by bits 20:16. The new value is visible one clock later.
- R4: While mode bit 24 stays 1, later host writes do not modify the bank, even if they change the address or data fields.
- R5: Bits 7:0 of `host_rdata` always show the entry selected by the stored address field. They follow a change of address in the clock after the host write, with no extra access cycle.
- R6: Entries whose bit in `IMPL_MASK` is clear read as 0x00 and ignore commits. With the default mask, the implemented addresses are 0,1,2,3,5,6,7,9,10,12,13 and 15.
- R7: `host_rdata` returns the stored bits 28, 24, 20:16 and 15:8 as last written. All other bits read 0, and host writes to bits 7:0 have no effect.
- R8: The observation outputs map bank fields as follows: `dac_en` = entry 3 bits 7:6, `lineout_vol` = entry 9 bits 7:3, `mic1_gain` = entry 6 bits 6:4, `mic2_gain` = entry 6 bits 2:0, `adc_en` = entry 15 bits 7:6, `adc_gain` = entry 15 bits 2:0.
- R9: A single host write that releases the port reset and raises the mode bit at the same time commits its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_wr | input | 1 | One-cycle strobe that loads the port register |
| host_wdata | input | 32 | Word written to the port register |
| host_rdata | output | 32 | Current port register value, with the bank entry in the low byte |
| dac_en | output | 2 | Output-path channel enables |
| lineout_vol | output | 5 | Line-output volume |
| mic1_gain | output | 3 | First microphone gain |
| mic2_gain | output | 3 | Second microphone gain |
| adc_en | output | 2 | Input-path channel enables |
| adc_gain | output | 3 | Input-path gain |

## Verification
A corrupted bank entry or a spurious commit shows up in one of two places. It appears in the low byte of `host_rdata` as soon as the host selects that address. For the mapped entries, it also appears on the observation outputs in the clock after the faulty update. A wrong edge detector on the mode bit shows up as a change to an entry while the mode bit is held at 1. A broken port-reset hold shows up as nonzero read data while bit 28 is 0. Either fault is visible one clock after the host write that provokes it.

// File: rtl/indirect_reg_port.sv
module indirect_reg_port #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int RST_BIT   = 28,
  parameter int MODE_BIT  = 24,
  parameter int ADDR_LSB  = 16,
  parameter int WDATA_LSB = 8,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 'hB6EF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [1:0]  dac_en,
  output logic [4:0]  lineout_vol,
  output logic [2:0]  mic1_gain,
  output logic [2:0]  mic2_gain,
  output logic [1:0]  adc_en,
  output logic [2:0]  adc_gain
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int A_DAC_SRC = 3;
  localparam int A_MICGAIN = 6;
  localparam int A_LOVOL   = 9;
  localparam int A_ADC_CTL = 15;

  logic              prst_q;
  logic              mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DEPTH-1:0][DATA_W-1:0] bank_w;

  wire              prst_nx = host_wr ? host_wdata[RST_BIT] : prst_q;
  wire              commit  = host_wr & host_wdata[RST_BIT] & host_wdata[MODE_BIT] & ~mode_q;
  wire [ADDR_W-1:0] waddr   = host_wdata[ADDR_LSB +: ADDR_W];
  wire [DATA_W-1:0] wbyte   = host_wdata[WDATA_LSB +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prst_q <= 1'b0;
      mode_q <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (host_wr) begin
      prst_q <= host_wdata[RST_BIT];
      mode_q <= host_wdata[MODE_BIT];
      addr_q <= waddr;
      wdat_q <= wbyte;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (IMPL_MASK[i]) begin : g_impl
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent_q <= '0;
        else if (!prst_nx)
          ent_q <= '0;
        else if (commit && waddr == ADDR_W'(i))
          ent_q <= wbyte;
      end
      assign bank_w[i] = ent_q;
    end else begin : g_hole
      assign bank_w[i] = '0;
    end
  end

  always_comb begin
    host_rdata                          = '0;
    host_rdata[RST_BIT]                 = prst_q;
    host_rdata[MODE_BIT]                = mode_q;
    host_rdata[ADDR_LSB +: ADDR_W]      = addr_q;
    host_rdata[WDATA_LSB +: DATA_W]     = wdat_q;
    host_rdata[DATA_W-1:0]              = bank_w[addr_q];
  end

  assign dac_en      = bank_w[A_DAC_SRC][7:6];
  assign lineout_vol = bank_w[A_LOVOL][7:3];
  assign mic1_gain   = bank_w[A_MICGAIN][6:4];
  assign mic2_gain   = bank_w[A_MICGAIN][2:0];
  assign adc_en      = bank_w[A_ADC_CTL][7:6];
  assign adc_gain    = bank_w[A_ADC_CTL][2:0];

endmodule

// File: rtl/indirect_reg_port_chk.sv
module indirect_reg_port_chk #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int RST_BIT   = 28,
  parameter int MODE_BIT  = 24,
  parameter int ADDR_LSB  = 16,
  parameter int WDATA_LSB = 8,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 'hB6EF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic [17:0] obs
);

  a_r2_held_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata[RST_BIT] |-> host_rdata[DATA_W-1:0] == '0);

  a_r4_mode_hold_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rdata[MODE_BIT] && host_wdata[MODE_BIT] && host_wdata[RST_BIT])
      |=> $stable(obs));

  a_r8_idle_obs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(obs));

  a_r6_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !IMPL_MASK[host_rdata[ADDR_LSB +: ADDR_W]] |-> host_rdata[DATA_W-1:0] == '0);

  a_r7_fields_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (host_rdata[31:DATA_W] ==
                 ($past(host_wdata[31:DATA_W]) &
                  ((24'(1) << (RST_BIT-DATA_W)) | (24'(1) << (MODE_BIT-DATA_W)) |
                   (24'((1<<ADDR_W)-1) << (ADDR_LSB-DATA_W)) |
                   (24'((1<<DATA_W)-1) << (WDATA_LSB-DATA_W))))));

endmodule

bind indirect_reg_port indirect_reg_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_BIT(RST_BIT), .MODE_BIT(MODE_BIT),
  .ADDR_LSB(ADDR_LSB), .WDATA_LSB(WDATA_LSB), .IMPL_MASK(IMPL_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .obs({dac_en, lineout_vol, mic1_gain, mic2_gain, adc_en, adc_gain})
);

// File: tb/indirect_reg_port_tb_top.sv
module indirect_reg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [1:0]  dac_en, adc_en;
  logic [4:0]  lineout_vol;
  logic [2:0]  mic1_gain, mic2_gain, adc_gain;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  indirect_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dac_en(dac_en), .lineout_vol(lineout_vol),
    .mic1_gain(mic1_gain), .mic2_gain(mic2_gain), .adc_en(adc_en), .adc_gain(adc_gain)
  );

  function automatic logic [31:0] word(bit prst, bit mode, logic [4:0] a, logic [7:0] d);
    return (32'(prst) << 28) | (32'(mode) << 24) | (32'(a) << 16) | (32'(d) << 8);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hw(logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic put(logic [4:0] a, logic [7:0] d);
    hw(word(1, 0, a, d));
    hw(word(1, 1, a, d));
  endtask

  task automatic get_chk(logic [4:0] a, logic [7:0] exp, string req);
    hw(word(1, 0, a, 8'h00));
    chk(host_rdata[7:0] == exp, req, 32'(host_rdata[7:0]), 32'(exp));
  endtask

  task automatic t_reset;
    chk(host_rdata == 32'h0, "R1 rdata", host_rdata, 32'h0);
    chk({dac_en, lineout_vol, mic1_gain, mic2_gain, adc_en, adc_gain} == '0, "R1 obs",
        32'({dac_en, lineout_vol, mic1_gain, mic2_gain, adc_en, adc_gain}), 32'h0);
  endtask

  task automatic t_write_read;
    put(5'd3, 8'hC0);
    chk(dac_en == 2'b11, "R3 R8 dac_en", 32'(dac_en), 32'h3);
    put(5'd15, 8'hC5);
    chk(adc_en == 2'b11 && adc_gain == 3'd5, "R8 adc fields", 32'({adc_en, adc_gain}), 32'h1D);
    put(5'd9, 8'hF8);
    chk(lineout_vol == 5'd31, "R8 lineout_vol", 32'(lineout_vol), 32'd31);
    put(5'd6, 8'h53);
    chk(mic1_gain == 3'd5 && mic2_gain == 3'd3, "R8 mic gains", 32'({mic1_gain, mic2_gain}), 32'h2B);
    put(5'd0, 8'hA5);
    chk(host_rdata[7:0] == 8'hA5, "R3 immediate readback", 32'(host_rdata[7:0]), 32'hA5);
    get_chk(5'd3, 8'hC0, "R5 read entry 3");
    get_chk(5'd9, 8'hF8, "R5 read entry 9");
    get_chk(5'd0, 8'hA5, "R5 read entry 0");
  endtask

  task automatic t_mode_hold;
    get_chk(5'd5, 8'h00, "R4 entry 5 initial");
    hw(word(1, 1, 5'd0, 8'hA5));
    hw(word(1, 1, 5'd0, 8'h11));
    hw(word(1, 1, 5'd5, 8'h22));
    hw(word(1, 1, 5'd3, 8'h00));
    chk(dac_en == 2'b11, "R4 dac_en kept", 32'(dac_en), 32'h3);
    get_chk(5'd0, 8'hA5, "R4 entry 0 kept");
    get_chk(5'd5, 8'h00, "R4 entry 5 kept");
  endtask

  task automatic t_holes;
    put(5'd4, 8'h77);
    chk(host_rdata[7:0] == 8'h00, "R6 addr 4", 32'(host_rdata[7:0]), 32'h0);
    put(5'd20, 8'h5A);
    get_chk(5'd20, 8'h00, "R6 addr 20");
    put(5'd1, 8'h3C);
    get_chk(5'd1, 8'h3C, "R6 implemented addr 1");
  endtask

  task automatic t_fields;
    hw(word(1, 0, 5'd31, 8'h00));
    hw(32'hFFFF_FFFF);
    chk(host_rdata == 32'h111F_FF00, "R7 field readback", host_rdata, 32'h111F_FF00);
    hw(32'h1000_00FF | word(1, 0, 5'd0, 8'h00));
    chk(host_rdata == 32'h1000_00A5, "R7 read byte ignores host", host_rdata, 32'h1000_00A5);
  endtask

  task automatic t_port_reset;
    hw(word(0, 0, 5'd0, 8'h00));
    chk(host_rdata == 32'h0, "R2 held reads zero", host_rdata, 32'h0);
    chk(dac_en == 2'b00 && lineout_vol == 5'd0 && adc_gain == 3'd0, "R2 obs cleared",
        32'({dac_en, lineout_vol, adc_gain}), 32'h0);
    hw(word(0, 1, 5'd3, 8'hFF));
    chk(dac_en == 2'b00, "R2 commit ignored", 32'(dac_en), 32'h0);
    hw(word(0, 0, 5'd3, 8'hFF));
    get_chk(5'd3, 8'h00, "R2 entry 3 still zero");
    get_chk(5'd1, 8'h00, "R2 entry 1 wiped");
  endtask

  task automatic t_combined;
    hw(word(0, 0, 5'd9, 8'h00));
    hw(word(1, 1, 5'd9, 8'h40));
    chk(lineout_vol == 5'd8, "R9 release and commit", 32'(lineout_vol), 32'd8);
    get_chk(5'd9, 8'h40, "R9 readback");
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_mode_hold();
    t_holes();
    t_fields();
    t_port_reset();
    t_combined();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule